// File: doc/BRIEF.md
# Registered-Widening / Latched-Narrowing Bus Exchanger

This block links one narrow bidirectional port (the A side) to two narrow lanes (lane 1 and lane 2) that together form a word of twice the width. Going from A to the lanes, each lane has a clocked capture register. Each register has its own active-low capture enable. When the two enables are asserted on consecutive clock edges, two successive A words are assembled into one wide word.

Going from the lanes back to A, each lane passes through a level-sensitive latch with its own active-low pass enable. A lane-select input picks which latch drives A. This path has no clock, so lane data reaches A within the same cycle whenever the chosen latch is open.

Each side has an active-low output enable. It appears as a drive-enable output next to separate input and output buses, in place of a tri-state net. While a side is not driven, its output data bus is held at zero.

Top module: `narrow_wide_xchg`

## Requirements
- R1: While rst_n is low at a rising clock edge, both capture registers clear to zero. While rst_n is low, both pass latches read zero, and they keep zero until their pass enable first goes low after reset.
- R2: At a rising edge with rst_n high, the lane 1 register loads a_i when cap1_en_n is low and keeps its value when cap1_en_n is high.
- R3: At a rising edge with rst_n high, the lane 2 register loads a_i when cap2_en_n is low and keeps its value when cap2_en_n is high.
- R4: When cap1_en_n and cap2_en_n are both low at the same edge, both registers load the same a_i word.
- R5: Asserting cap1_en_n at one edge and cap2_en_n at the next edge presents the first A word on b1_o and the second on b2_o.
- R6: The lane 1 latch follows b1_i while pass1_en_n is low and holds its last value while pass1_en_n is high.
- R7: The lane 2 latch follows b2_i while pass2_en_n is low and holds its last value while pass2_en_n is high.
- R8: With lane_sel = 0, a_o carries the lane 1 latch; with lane_sel = 1, it carries the lane 2 latch.
- R9: A change on b1_i or b2_i reaches a_o without a clock edge when the selected latch is open and a_oe_n is low.
- R10: a_drive equals 1 exactly when a_oe_n is low. While a_drive is 0, a_o is zero.
- R11: b_drive equals 1 exactly when b_oe_n is low. While b_drive is 1, b1_o and b2_o show the lane registers; otherwise both are zero. The registered lane outputs change only after a rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Active-low reset, synchronous for the registers and level-acting for the latches |
| a_i | input | 12 | Data arriving on the A side |
| a_o | output | 12 | Data sent out on the A side |
| a_drive | output | 1 | A side drive enable |
| b1_i | input | 12 | Data arriving on lane 1 |
| b2_i | input | 12 | Data arriving on lane 2 |
| b1_o | output | 12 | Lane 1 registered output |
| b2_o | output | 12 | Lane 2 registered output |
| b_drive | output | 1 | Drive enable for both lanes |
| cap1_en_n | input | 1 | Lane 1 capture enable, active low |
| cap2_en_n | input | 1 | Lane 2 capture enable, active low |
| pass1_en_n | input | 1 | Lane 1 latch pass enable, active low |
| pass2_en_n | input | 1 | Lane 2 latch pass enable, active low |
| lane_sel | input | 1 | Chooses the latch that feeds A (0 = lane 1, 1 = lane 2) |
| a_oe_n | input | 1 | A side output enable, active low |
| b_oe_n | input | 1 | Lane output enable, active low |

## Verification
At every clock edge the assertions check these properties:
- the capture registers load or hold according to their enables;
- the clearing by reset;
- the match between an open latch and its lane input;
- that a_o follows the chosen latch;
- that the lane outputs follow the registers.

Only the bench scenarios can show the following:
- that a lane change reaches a_o between clock edges;
- that a closed latch ignores later lane activity;
- the assembly of two consecutive A words into one wide word.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
   typedef enum logic {
      PICK_LANE1 = 1'b0,
      PICK_LANE2 = 1'b1
   } lane_pick_e;

   localparam int unsigned NUM_LANES = 2;
endpackage

// File: rtl/xchg_cap_reg.sv
module xchg_cap_reg #(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_width
      $error("xchg_cap_reg: W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     q <= '0;
      else if (!en_n) q <= d;
   end
endmodule

// File: rtl/xchg_pass_latch.sv
module xchg_pass_latch #(
   parameter int unsigned W = 12
) (
   input  logic         rst_n,
   input  logic         le_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_width
      $error("xchg_pass_latch: W must be at least 1");
   end

   always_latch begin
      if (!rst_n)     q <= '0;
      else if (!le_n) q <= d;
   end
endmodule

// File: rtl/xchg_drive.sv
module xchg_drive #(
   parameter int unsigned W         = 12,
   parameter bit          GATE_IDLE = 1'b1
) (
   input  logic         oe_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic         drv
);
   assign drv = ~oe_n;

   if (GATE_IDLE) begin : g_gated
      assign q = drv ? d : '0;
   end else begin : g_raw
      assign q = d;
   end
endmodule

// File: rtl/narrow_wide_xchg.sv
module narrow_wide_xchg #(
   parameter int unsigned LANE_W    = 12,
   parameter bit          GATE_IDLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LANE_W-1:0] a_i,
   output logic [LANE_W-1:0] a_o,
   output logic              a_drive,
   input  logic [LANE_W-1:0] b1_i,
   input  logic [LANE_W-1:0] b2_i,
   output logic [LANE_W-1:0] b1_o,
   output logic [LANE_W-1:0] b2_o,
   output logic              b_drive,
   input  logic              cap1_en_n,
   input  logic              cap2_en_n,
   input  logic              pass1_en_n,
   input  logic              pass2_en_n,
   input  logic              lane_sel,
   input  logic              a_oe_n,
   input  logic              b_oe_n
);
   import xchg_pkg::*;

   localparam int unsigned WIDE_W = LANE_W * NUM_LANES;

   if (LANE_W < 1) begin : g_bad_lane
      $error("narrow_wide_xchg: LANE_W must be at least 1");
   end

   logic [NUM_LANES-1:0] cap_en_n;
   logic [NUM_LANES-1:0] pass_en_n;
   logic [LANE_W-1:0]    lane_in  [NUM_LANES];
   logic [LANE_W-1:0]    lane_reg [NUM_LANES];
   logic [LANE_W-1:0]    lane_lat [NUM_LANES];
   logic [WIDE_W-1:0]    wide_reg;
   logic [WIDE_W-1:0]    wide_out;
   logic [LANE_W-1:0]    a_pick;
   lane_pick_e           pick;
   logic                 b_drv_int;

   assign cap_en_n  = {cap2_en_n, cap1_en_n};
   assign pass_en_n = {pass2_en_n, pass1_en_n};
   assign lane_in[0] = b1_i;
   assign lane_in[1] = b2_i;

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      xchg_cap_reg #(.W(LANE_W)) u_cap (
         .clk  (clk),
         .rst_n(rst_n),
         .en_n (cap_en_n[g]),
         .d    (a_i),
         .q    (lane_reg[g])
      );
      xchg_pass_latch #(.W(LANE_W)) u_lat (
         .rst_n(rst_n),
         .le_n (pass_en_n[g]),
         .d    (lane_in[g]),
         .q    (lane_lat[g])
      );
      assign wide_reg[g*LANE_W +: LANE_W] = lane_reg[g];
   end

   assign pick   = lane_pick_e'(lane_sel);
   assign a_pick = (pick == PICK_LANE2) ? lane_lat[1] : lane_lat[0];

   xchg_drive #(.W(LANE_W), .GATE_IDLE(GATE_IDLE)) u_drv_a (
      .oe_n(a_oe_n),
      .d   (a_pick),
      .q   (a_o),
      .drv (a_drive)
   );

   xchg_drive #(.W(WIDE_W), .GATE_IDLE(GATE_IDLE)) u_drv_b (
      .oe_n(b_oe_n),
      .d   (wide_reg),
      .q   (wide_out),
      .drv (b_drv_int)
   );

   assign b_drive = b_drv_int;
   assign b1_o    = wide_out[0 +: LANE_W];
   assign b2_o    = wide_out[LANE_W +: LANE_W];
endmodule

// File: rtl/narrow_wide_xchg_chk.sv
module narrow_wide_xchg_chk #(
   parameter int unsigned LANE_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic [LANE_W-1:0] a_i,
   input logic [LANE_W-1:0] a_o,
   input logic              a_drive,
   input logic [LANE_W-1:0] b1_i,
   input logic [LANE_W-1:0] b2_i,
   input logic [LANE_W-1:0] b1_o,
   input logic [LANE_W-1:0] b2_o,
   input logic              b_drive,
   input logic              cap1_en_n,
   input logic              cap2_en_n,
   input logic              pass1_en_n,
   input logic              pass2_en_n,
   input logic              lane_sel,
   input logic [LANE_W-1:0] reg1_q,
   input logic [LANE_W-1:0] reg2_q,
   input logic [LANE_W-1:0] lat1_q,
   input logic [LANE_W-1:0] lat2_q
);
   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (reg1_q == '0) && (reg2_q == '0));

   assert_lane1_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cap1_en_n |=> reg1_q == $past(a_i));

   assert_lane1_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cap1_en_n |=> $stable(reg1_q));

   assert_lane2_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cap2_en_n |=> reg2_q == $past(a_i));

   assert_lane2_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cap2_en_n |=> $stable(reg2_q));

   assert_lat1_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !pass1_en_n |-> lat1_q == b1_i);

   assert_lat2_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !pass2_en_n |-> lat2_q == b2_i);

   assert_sel_lane1_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (a_drive && !lane_sel) |-> a_o == lat1_q);

   assert_sel_lane2_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (a_drive && lane_sel) |-> a_o == lat2_q);

   assert_a_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !a_drive |-> a_o == '0);

   assert_b_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      b_drive |-> (b1_o == reg1_q) && (b2_o == reg2_q));
endmodule

bind narrow_wide_xchg narrow_wide_xchg_chk #(.LANE_W(LANE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .a_i       (a_i),
   .a_o       (a_o),
   .a_drive   (a_drive),
   .b1_i      (b1_i),
   .b2_i      (b2_i),
   .b1_o      (b1_o),
   .b2_o      (b2_o),
   .b_drive   (b_drive),
   .cap1_en_n (cap1_en_n),
   .cap2_en_n (cap2_en_n),
   .pass1_en_n(pass1_en_n),
   .pass2_en_n(pass2_en_n),
   .lane_sel  (lane_sel),
   .reg1_q    (lane_reg[0]),
   .reg2_q    (lane_reg[1]),
   .lat1_q    (lane_lat[0]),
   .lat2_q    (lane_lat[1])
);

// File: tb/sim_narrow_wide_xchg.sv
`timescale 1ns/1ps
module sim_narrow_wide_xchg;
   localparam int W = 12;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [W-1:0] a_i, b1_i, b2_i;
   logic [W-1:0] a_o, b1_o, b2_o;
   logic         a_drive, b_drive;
   logic         cap1_en_n, cap2_en_n, pass1_en_n, pass2_en_n;
   logic         lane_sel, a_oe_n, b_oe_n;

   int unsigned  n_run  = 0;
   int unsigned  n_fail = 0;
   bit           done   = 1'b0;

   logic [W-1:0] m_reg1, m_reg2, m_lat1, m_lat2;

   always #10 clk = ~clk;

   narrow_wide_xchg u0 (
      .clk(clk), .rst_n(rst_n),
      .a_i(a_i), .a_o(a_o), .a_drive(a_drive),
      .b1_i(b1_i), .b2_i(b2_i), .b1_o(b1_o), .b2_o(b2_o), .b_drive(b_drive),
      .cap1_en_n(cap1_en_n), .cap2_en_n(cap2_en_n),
      .pass1_en_n(pass1_en_n), .pass2_en_n(pass2_en_n),
      .lane_sel(lane_sel), .a_oe_n(a_oe_n), .b_oe_n(b_oe_n)
   );

   function automatic logic [W-1:0] exp_a();
      logic [W-1:0] v;
      v = lane_sel ? m_lat2 : m_lat1;
      return a_oe_n ? '0 : v;
   endfunction

   function automatic logic [W-1:0] exp_b(input logic [W-1:0] r);
      return b_oe_n ? '0 : r;
   endfunction

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // model latches track inputs at the moment they are driven
   task automatic upd_lat();
      if (!rst_n) begin
         m_lat1 = '0;
         m_lat2 = '0;
      end else begin
         if (!pass1_en_n) m_lat1 = b1_i;
         if (!pass2_en_n) m_lat2 = b2_i;
      end
   endtask

   // model registers for the coming rising edge
   task automatic upd_reg();
      if (!rst_n) begin
         m_reg1 = '0;
         m_reg2 = '0;
      end else begin
         if (!cap1_en_n) m_reg1 = a_i;
         if (!cap2_en_n) m_reg2 = a_i;
      end
   endtask

   task automatic check_all(input string tag);
      chk({tag, " R8 a_o"}, a_o, exp_a());
      chk({tag, " R10 a_drive"}, W'(a_drive), W'(!a_oe_n));
      chk({tag, " R11 b_drive"}, W'(b_drive), W'(!b_oe_n));
      chk({tag, " R2 b1_o"}, b1_o, exp_b(m_reg1));
      chk({tag, " R3 b2_o"}, b2_o, exp_b(m_reg2));
   endtask

   task automatic quiet();
      cap1_en_n = 1'b1; cap2_en_n = 1'b1;
      pass1_en_n = 1'b1; pass2_en_n = 1'b1;
      a_oe_n = 1'b0; b_oe_n = 1'b0; lane_sel = 1'b0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd4711));
      rst_n = 1'b0;
      a_i = 12'h5A5; b1_i = 12'h111; b2_i = 12'h222;
      quiet();
      m_reg1 = '0; m_reg2 = '0; m_lat1 = '0; m_lat2 = '0;

      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 b1_o after reset", b1_o, 12'h000);
      chk("R1 b2_o after reset", b2_o, 12'h000);
      chk("R1 lane1 latch after reset", a_o, 12'h000);
      lane_sel = 1'b1;
      #1;
      chk("R1 lane2 latch after reset", a_o, 12'h000);
      lane_sel = 1'b0;

      // R5: assemble two successive words
      @(negedge clk);
      a_i = 12'h123; cap1_en_n = 1'b0; upd_reg();
      @(negedge clk);
      a_i = 12'h456; cap1_en_n = 1'b1; cap2_en_n = 1'b0; upd_reg();
      @(negedge clk);
      cap2_en_n = 1'b1; a_i = 12'hFFF;
      #1;
      chk("R5 first word on b1_o", b1_o, 12'h123);
      chk("R5 second word on b2_o", b2_o, 12'h456);

      // R4: both enables on one edge
      a_i = 12'hABC; cap1_en_n = 1'b0; cap2_en_n = 1'b0; upd_reg();
      @(negedge clk);
      quiet();
      #1;
      chk("R4 b1_o both enables", b1_o, 12'hABC);
      chk("R4 b2_o both enables", b2_o, 12'hABC);

      // R11: registered lanes do not change without an edge
      a_i = 12'h0F0; cap1_en_n = 1'b0;
      #4;
      chk("R11 b1_o stable before edge", b1_o, 12'hABC);
      b_oe_n = 1'b1;
      #1;
      chk("R11 b1_o idle", b1_o, 12'h000);
      chk("R11 b_drive idle", W'(b_drive), 12'h000);
      upd_reg();
      @(negedge clk);
      quiet();

      // R9 and R6: same-cycle pass-through, then hold
      pass1_en_n = 1'b0; b1_i = 12'h3C3; upd_lat();
      #1;
      chk("R9 a_o follows b1_i", a_o, 12'h3C3);
      b1_i = 12'h7E1; upd_lat();
      #2;
      chk("R9 a_o follows b1_i change mid-cycle", a_o, 12'h7E1);
      pass1_en_n = 1'b1;
      #1;
      b1_i = 12'h000;
      #1;
      chk("R6 lane1 latch holds", a_o, 12'h7E1);

      // R7: lane 2 pass and hold
      lane_sel = 1'b1; pass2_en_n = 1'b0; b2_i = 12'h9D2; upd_lat();
      #1;
      chk("R7 lane2 transparent", a_o, 12'h9D2);
      pass2_en_n = 1'b1;
      #1;
      b2_i = 12'h444;
      #1;
      chk("R7 lane2 holds", a_o, 12'h9D2);

      // R10: A side disabled
      a_oe_n = 1'b1;
      #1;
      chk("R10 a_o idle", a_o, 12'h000);
      chk("R10 a_drive idle", W'(a_drive), 12'h000);

      // random mix
      for (int i = 0; i < 1500; i++) begin
         @(negedge clk);
         a_i        = W'($urandom);
         b1_i       = W'($urandom);
         b2_i       = W'($urandom);
         cap1_en_n  = ($urandom % 3) != 0;
         cap2_en_n  = ($urandom % 3) != 0;
         pass1_en_n = ($urandom % 2) != 0;
         pass2_en_n = ($urandom % 2) != 0;
         lane_sel   = $urandom % 2;
         a_oe_n     = ($urandom % 4) == 0;
         b_oe_n     = ($urandom % 4) == 0;
         upd_lat();
         #1;
         check_all("rand");
         upd_reg();
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule